// File: doc/BRIEF.md
# Timed-Window Configuration Bit Access Controller

This block holds the nonvolatile configuration bytes of a small microcontroller (a fuse low byte, a fuse high byte and a lock byte) and the guarded path through which the CPU reads and programs them. The CPU writes a control register with both its select flag and its enable flag set. That write arms a short access window, which a cycle counter tracks.

A program-memory load strobe that arrives early enough in the window returns one of the configuration bytes instead of memory data. A 16-bit pointer chooses which byte. A store strobe that arrives in the window programs the boot lock bits from a data byte. The window closes by itself once it has been used or once it runs out of time. While an EEPROM write is in progress, the block refuses both windowed reads and lock programming. Outside the window, loads pass straight through from program memory.

Programmed bits read as 0 and unprogrammed bits read as 1. Programming can only move a bit from 1 to 0.

Top module: `cfg_window_ctrl`

## Requirements
- R1: After reset the window is closed (`win_open` low), and `rd_data` equals `flash_rdata`.
- R2: A control write with both `ctl_sel` and `ctl_en` high and `ee_busy` low opens the window from the next clock edge. The same write with `ee_busy` high leaves the window closed.
- R3: A load strobe in any of the first `RD_WIN` (default 3) open cycles returns a byte chosen by `zptr` in the same cycle. 0x0001 selects the lock byte, 0x0000 the fuse low byte and 0x0003 the fuse high byte. Any other pointer value returns 0xFF. The window closes at the next edge.
- R4: A load strobe in an open cycle past the first `RD_WIN` cycles returns `flash_rdata`.
- R5: A store strobe in any of the first `WR_WIN` (default 4) open cycles sets lock bits 5..2 to their current value ANDed with `st_data[5:2]`, and the window then closes. `zptr` and the other `st_data` bits have no effect.
- R6: An armed window that sees no accepted access closes by itself after `WR_WIN` cycles. A store strobe after that point changes nothing.
- R7: Lock bits never change from 0 to 1. Bits 1..0 are never programmed by this block. Lock bits 7..6 always read as 1.
- R8: While `ee_busy` is high, a load strobe returns `flash_rdata` and a store strobe leaves the lock byte unchanged.
- R9: With the window closed, a load strobe returns `flash_rdata` unchanged.
- R10: When load and store strobes arrive in the same open cycle, the load is served, the store is dropped and the window closes.
- R11: Re-arming an open window restarts its cycle count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_sel | input | 1 | Lock/fuse select flag in the control write |
| ctl_en | input | 1 | Store enable flag in the control write |
| ee_busy | input | 1 | EEPROM write in progress |
| ld_stb | input | 1 | Program-memory load strobe |
| st_stb | input | 1 | Program-memory store strobe |
| zptr | input | 16 | Address pointer |
| st_data | input | 8 | Store data byte |
| flash_rdata | input | 8 | Ordinary program-memory read data |
| rd_data | output | 8 | Load result |
| win_open | output | 1 | Access window currently armed |

## Verification
The hardest cases to reach sit at the edges of the window: a load in the fourth open cycle, where a store would still be accepted but the load is no longer served, and a store in exactly the last open cycle. The stimulus reaches these by arming and then idling a counted number of cycles before striking. A table row supplies the delay for each load. Re-arming partway through the window is also covered. The bench shows the restarted count by serving a load at a point the old count would already have expired.

// File: rtl/cfg_window_ctrl.sv
module cfg_window_ctrl #(
  parameter logic [7:0] FUSE_LO_INIT = 8'hE1,
  parameter logic [7:0] FUSE_HI_INIT = 8'h99,
  parameter logic [7:0] LOCK_INIT    = 8'hFF,
  parameter int         RD_WIN       = 3,
  parameter int         WR_WIN       = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic        ctl_sel,
  input  logic        ctl_en,
  input  logic        ee_busy,
  input  logic        ld_stb,
  input  logic        st_stb,
  input  logic [15:0] zptr,
  input  logic [7:0]  st_data,
  input  logic [7:0]  flash_rdata,
  output logic [7:0]  rd_data,
  output logic        win_open
);
  localparam int CW = $clog2(WR_WIN + 1);
  localparam logic [CW-1:0] RD_LIM = CW'(RD_WIN);
  localparam logic [CW-1:0] WR_LIM = CW'(WR_WIN);
  localparam logic [CW-1:0] LAST   = CW'(WR_WIN - 1);

  logic [CW-1:0] cnt;
  logic [7:0]    lock_q;
  logic [7:0]    cfg_byte;
  logic          ld_hit, st_hit, arm;

  assign arm    = ctl_wr && ctl_sel && ctl_en && !ee_busy;
  assign ld_hit = win_open && ld_stb && !ee_busy && (cnt < RD_LIM);
  assign st_hit = win_open && st_stb && !ld_stb && !ee_busy && (cnt < WR_LIM);

  always_comb begin
    case (zptr)
      16'h0000: cfg_byte = FUSE_LO_INIT;
      16'h0001: cfg_byte = lock_q;
      16'h0003: cfg_byte = FUSE_HI_INIT;
      default:  cfg_byte = 8'hFF;
    endcase
  end

  assign rd_data = ld_hit ? cfg_byte : flash_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_open <= 1'b0;
      cnt      <= '0;
      lock_q   <= LOCK_INIT | 8'hC0;
    end else begin
      if (ctl_wr) begin
        win_open <= arm;
        cnt      <= '0;
      end else if (win_open) begin
        if (ld_hit || st_hit || cnt == LAST) win_open <= 1'b0;
        cnt <= cnt + 1'b1;
      end
      if (st_hit && !ctl_wr)
        lock_q[5:2] <= lock_q[5:2] & st_data[5:2];
    end
  end

  AST_BUSY_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ee_busy |=> !win_open); // R2
  AST_WIN_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    win_open && cnt == LAST && !ctl_wr |=> !win_open); // R6
  AST_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lock_q & ~$past(lock_q)) == 8'h00); // R7
  AST_TOP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[7:6] == 2'b11); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ee_busy |=> $stable(lock_q)); // R8
  AST_CLOSED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |-> rd_data == flash_rdata); // R9
  AST_LOAD_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit && !ctl_wr |=> !win_open); // R3
endmodule

// File: tb/tb_cfg_window_ctrl.sv
module tb_cfg_window_ctrl;
  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, ctl_sel = 0, ctl_en = 0, ee_busy = 0, ld_stb = 0, st_stb = 0;
  logic [15:0] zptr = 0;
  logic [7:0] st_data = 8'hFF, flash_rdata = 8'h5A, rd_data;
  logic win_open;
  int nchk = 0, nbad = 0;

  always #4 clk = ~clk;

  cfg_window_ctrl #(.FUSE_LO_INIT(8'hE1), .FUSE_HI_INIT(8'h99), .LOCK_INIT(8'hFE),
                    .RD_WIN(3), .WR_WIN(4)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_sel(ctl_sel), .ctl_en(ctl_en),
    .ee_busy(ee_busy), .ld_stb(ld_stb), .st_stb(st_stb), .zptr(zptr),
    .st_data(st_data), .flash_rdata(flash_rdata), .rd_data(rd_data), .win_open(win_open));

  // {delay, pointer, expected}
  localparam logic [27:0] VEC [7] = '{
    {4'd0, 16'h0001, 8'hFE}, {4'd1, 16'h0000, 8'hE1}, {4'd2, 16'h0003, 8'h99},
    {4'd0, 16'h0002, 8'hFF}, {4'd3, 16'h0001, 8'h5A}, {4'd2, 16'hFFFF, 8'hFF},
    {4'd1, 16'h0003, 8'h99}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic arm(input logic busy);
    @(negedge clk);
    ctl_wr = 1; ctl_sel = 1; ctl_en = 1; ee_busy = busy;
    @(negedge clk);
    ctl_wr = 0; ctl_sel = 0; ctl_en = 0; ee_busy = 0;
  endtask

  task automatic load(input logic [15:0] p, output logic [7:0] r);
    ld_stb = 1; zptr = p; #2 r = rd_data;
    @(negedge clk); ld_stb = 0;
  endtask

  task automatic store(input logic [7:0] d);
    st_stb = 1; st_data = d; zptr = 16'h1234;
    @(negedge clk); st_stb = 0;
  endtask

  task automatic lockval(output logic [7:0] r);
    arm(0); load(16'h0001, r);
  endtask

  initial begin
    #200000;
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 win", {7'b0, win_open}, 8'h00);
    chk("R1 rd", rd_data, 8'h5A);
    ld_stb = 1; zptr = 16'h0001; #2 chk("R9 pass", rd_data, 8'h5A);
    @(negedge clk); ld_stb = 0;

    for (int i = 0; i < 7; i++) begin
      arm(0);
      chk("R2 open", {7'b0, win_open}, 8'h01);
      repeat (VEC[i][27:24]) @(negedge clk);
      load(VEC[i][23:8], r);
      chk(VEC[i][27:24] == 3 ? "R4 late" : "R3 read", r, VEC[i][7:0]);
      chk("R3 close", {7'b0, win_open}, 8'h00);
    end

    arm(1);
    chk("R2 busy arm", {7'b0, win_open}, 8'h00);

    arm(0); @(negedge clk); store(8'hF7);
    chk("R5 close", {7'b0, win_open}, 8'h00);
    lockval(r); chk("R5 prog", r, 8'hF6);

    arm(0); store(8'h3C);
    lockval(r); chk("R7 no raise", r, 8'hF6);

    arm(0); repeat (3) @(negedge clk); store(8'hDF);
    lockval(r); chk("R5 last cycle", r, 8'hD6);

    arm(0); repeat (4) @(negedge clk);
    chk("R6 timeout", {7'b0, win_open}, 8'h00);
    store(8'h00);
    lockval(r); chk("R6 late store", r, 8'hD6);

    arm(0); ee_busy = 1; load(16'h0001, r); ee_busy = 0;
    chk("R8 busy read", r, 8'h5A);
    arm(0); ee_busy = 1; store(8'h00); ee_busy = 0;
    lockval(r); chk("R8 busy store", r, 8'hD6);

    arm(0); st_stb = 1; st_data = 8'h00; load(16'h0001, r); st_stb = 0;
    chk("R10 load wins", r, 8'hD6);
    chk("R10 close", {7'b0, win_open}, 8'h00);
    lockval(r); chk("R10 store dropped", r, 8'hD6);

    arm(0); repeat (2) @(negedge clk); arm(0); repeat (2) @(negedge clk);
    load(16'h0000, r); chk("R11 rearm", r, 8'hE1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule